// File: doc/BRIEF.md
# Super-Pixel Readout Concentrator

This block gathers hit records from eight pixels that share one readout group. Each pixel has a request line and a one-bit serial output. A single round-robin token picks which pixel may shift its record in. The block builds a 40-bit record from the pixel's payload and the pixel's index and places it in a two-entry buffer. It then sends the record over a shared column bus as 8-bit words, most significant word first.

The end-of-column side can assert a full signal at any time. Transmission then pauses and resumes later with no lost or repeated words. Because of this, the buffer never overflows. The gap between two serial transfers is set at run time by extending the shift count by a configurable number of idle cycles. In gated mode, tokens are granted only while the shutter is closed. In continuous mode, the shutter is ignored.

Top module: `sp_readout_conc`

## Requirements
- R1: At most one token line is high at any time, and a token is granted only to a pixel whose request was high in the cycle before the token rises.
- R2: Tokens are granted round-robin, starting from the pixel after the one served last. After reset, pixel 0 has first priority.
- R3: A granted token stays high for exactly 37 consecutive cycles. The pixel drives one payload bit per token cycle, MSB first, and the block samples each bit at the end of that cycle.
- R4: After a token falls, no token is high for dead_cfg_i + 1 cycles before the next grant, provided the buffer has room.
- R5: A record is {pixel index in bits 39:37, payload in bits 36:0}. It is sent as 5 words, with word k carrying record bits [39-8k -: 8]. col_dp_o stays high through all the words of a record.
- R6: A word is transferred in every cycle where col_dp_o=1 and eoc_full_i=0. While eoc_full_i=1, col_data_o holds its value and no word is consumed.
- R7: At most three records are held (two buffered, one in the transmitter). No token is granted while the buffer is full, and every held record is delivered once the full signal is released.
- R8: With mode_i=1 (gated), no token is granted while shutter_i=1. With mode_i=0 (continuous), shutter_i has no effect on granting.
- R9: During and immediately after reset, all token lines are low and col_dp_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pix_req_i | input | 8 | Per-pixel hit request |
| pix_ser_i | input | 8 | Per-pixel serial payload bit |
| pix_tok_o | output | 8 | One-hot token to the pixel allowed to shift |
| mode_i | input | 1 | 0 = continuous, 1 = gated by shutter |
| shutter_i | input | 1 | 1 = shutter open (acquiring) |
| dead_cfg_i | input | 4 | Extra idle cycles after each serial transfer |
| eoc_full_i | input | 1 | End-of-column back-pressure |
| col_data_o | output | 8 | Column bus word |
| col_dp_o | output | 1 | Data present on the column bus |

## Verification
A wrong arbiter pointer shows up as a wrong grant order at the token pins as soon as two pixels request together. A wrong shift or dead-time count changes the token width or the token gap within one transfer, and corrupts the record fields seen on the column bus a few cycles later. A wrong buffer count or a wrong transmitter word count shows up during a long full period: either more than three tokens are granted, or words go missing or are duplicated once the full signal drops.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic {
        MODE_CONT  = 1'b0,
        MODE_GATED = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/sp_rr_arb.sv
module sp_rr_arb #(
    parameter int NPIX   = 8,
    parameter int ADDR_W = $clog2(NPIX)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPIX-1:0]   req_i,
    input  logic              grant_i,
    output logic              any_o,
    output logic [ADDR_W-1:0] win_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        any_o = 1'b0;
        win_o = '0;
        for (int k = 1; k <= NPIX; k++) begin
            automatic int idx = (int'(st_q.last) + k) % NPIX;
            if (!any_o && req_i[idx]) begin
                any_o = 1'b1;
                win_o = ADDR_W'(idx);
            end
        end
        if (grant_i) st_d.last = win_o;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.last <= ADDR_W'(NPIX - 1);
        else         st_q <= st_d;
    end

    AST_GRANT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_i |-> any_o && req_i[win_o]); // R1
endmodule

// File: rtl/sp_deser.sv
module sp_deser #(
    parameter int NPIX   = 8,
    parameter int PAY_W  = 37,
    parameter int DEAD_W = 4,
    parameter int ADDR_W = $clog2(NPIX),
    parameter int REC_W  = ADDR_W + PAY_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] win_i,
    input  logic [NPIX-1:0]   ser_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic [NPIX-1:0]   tok_o,
    output logic              active_o,
    output logic              push_o,
    output logic [REC_W-1:0]  rec_o
);
    localparam int CNT_W = $clog2(PAY_W + (1 << DEAD_W) + 1);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] sel;
        logic [CNT_W-1:0]  cnt;
        logic [PAY_W-1:0]  sh;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] last_cnt;
    logic             shifting;

    assign last_cnt = CNT_W'(PAY_W - 1) + CNT_W'(dead_i);
    assign shifting = st_q.active && (st_q.cnt < CNT_W'(PAY_W));

    always_comb begin
        st_d   = st_q;
        push_o = 1'b0;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.sel    = win_i;
                st_d.cnt    = '0;
            end
        end else begin
            if (shifting) st_d.sh = {st_q.sh[PAY_W-2:0], ser_i[st_q.sel]};
            if (st_q.cnt == last_cnt) begin
                st_d.active = 1'b0;
                push_o      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    assign rec_o    = {st_q.sel, st_d.sh};
    assign active_o = st_q.active;
    assign tok_o    = shifting ? (NPIX'(1) << st_q.sel) : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_TOK_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(|tok_o) |-> $past(st_q.cnt) == CNT_W'(PAY_W - 1)); // R3
    AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.active && !push_o |=> st_q.active && $stable(st_q.sel)); // R3
endmodule

// File: rtl/sp_rec_fifo.sv
module sp_rec_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [PW:0]             cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wp] = din_i;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop_i) st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (push_i && !pop_i)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_i && !push_i) st_d.cnt = st_q.cnt - 1'b1;
    end

    assign dout_o  = st_q.mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == (PW+1)'(DEPTH));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> !full_o); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o); // R7
endmodule

// File: rtl/sp_bus_tx.sv
module sp_bus_tx #(
    parameter int REC_W = 40,
    parameter int BUS_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [REC_W-1:0] rec_i,
    input  logic             avail_i,
    input  logic             full_i,
    output logic             pop_o,
    output logic [BUS_W-1:0] data_o,
    output logic             dp_o
);
    localparam int NWORDS = (REC_W + BUS_W - 1) / BUS_W;
    localparam int PAD_W  = NWORDS * BUS_W;
    localparam int WC_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    typedef struct packed {
        logic             busy;
        logic [WC_W-1:0]  wcnt;
        logic [PAD_W-1:0] sh;
    } st_t;

    st_t  st_d, st_q;
    logic adv, lastw, load;

    assign adv   = st_q.busy && !full_i;
    assign lastw = (st_q.wcnt == WC_W'(NWORDS - 1));
    assign load  = (!st_q.busy || (adv && lastw)) && avail_i;

    always_comb begin
        st_d  = st_q;
        pop_o = 1'b0;
        if (adv) begin
            if (lastw) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.sh   = st_q.sh << BUS_W;
                st_d.wcnt = st_q.wcnt + 1'b1;
            end
        end
        if (load) begin
            pop_o     = 1'b1;
            st_d.busy = 1'b1;
            st_d.wcnt = '0;
            st_d.sh   = PAD_W'(rec_i) << (PAD_W - REC_W);
        end
    end

    assign data_o = st_q.sh[PAD_W-1 -: BUS_W];
    assign dp_o   = st_q.busy;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dp_o && full_i |=> dp_o && $stable(data_o)); // R6
    AST_WCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wcnt <= WC_W'(NWORDS - 1)); // R5
endmodule

// File: rtl/sp_readout_conc.sv
module sp_readout_conc
    import sp_pkg::*;
#(
    parameter int NPIX       = 8,
    parameter int PAY_W      = 37,
    parameter int BUS_W      = 8,
    parameter int DEAD_W     = 4,
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPIX-1:0]   pix_req_i,
    input  logic [NPIX-1:0]   pix_ser_i,
    output logic [NPIX-1:0]   pix_tok_o,
    input  logic              mode_i,
    input  logic              shutter_i,
    input  logic [DEAD_W-1:0] dead_cfg_i,
    input  logic              eoc_full_i,
    output logic [BUS_W-1:0]  col_data_o,
    output logic              col_dp_o
);
    localparam int ADDR_W = $clog2(NPIX);
    localparam int REC_W  = ADDR_W + PAY_W;

    logic              any_req, start, active, push, pop, fifo_empty, fifo_full, gate_ok;
    logic [ADDR_W-1:0] win;
    logic [REC_W-1:0]  rec_in, rec_out;

    assign gate_ok = (rd_mode_e'(mode_i) == MODE_CONT) || !shutter_i;
    assign start   = !active && any_req && !fifo_full && gate_ok;

    sp_rr_arb #(.NPIX(NPIX), .ADDR_W(ADDR_W)) u_arb (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(pix_req_i),
        .grant_i(start), .any_o(any_req), .win_o(win)
    );

    sp_deser #(.NPIX(NPIX), .PAY_W(PAY_W), .DEAD_W(DEAD_W),
               .ADDR_W(ADDR_W), .REC_W(REC_W)) u_deser (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .win_i(win),
        .ser_i(pix_ser_i), .dead_i(dead_cfg_i), .tok_o(pix_tok_o),
        .active_o(active), .push_o(push), .rec_o(rec_in)
    );

    sp_rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .din_i(rec_in),
        .pop_i(pop), .dout_o(rec_out), .empty_o(fifo_empty), .full_o(fifo_full)
    );

    sp_bus_tx #(.REC_W(REC_W), .BUS_W(BUS_W)) u_tx (
        .clk_i(clk_i), .rst_ni(rst_ni), .rec_i(rec_out), .avail_i(!fifo_empty),
        .full_i(eoc_full_i), .pop_o(pop), .data_o(col_data_o), .dp_o(col_dp_o)
    );

    AST_TOK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(pix_tok_o)); // R1
    AST_TOK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|pix_tok_o) |-> (($past(pix_req_i) & pix_tok_o) != '0)); // R1
    AST_SHUTTER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|pix_tok_o) && $past(mode_i) |-> !$past(shutter_i)); // R8
endmodule

// File: tb/sp_readout_conc_tb.sv
module sp_readout_conc_tb;
    localparam int NP = 8;
    localparam int PW = 37;
    localparam int NW = 5;

    typedef struct packed {
        logic [7:0] mask;
        logic       mode;
        logic       shut;
        logic [3:0] dead;
        logic [7:0] stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'b0000_0001, 1'b0, 1'b0, 4'd0,  8'h00},
        '{8'b1111_1111, 1'b0, 1'b1, 4'd3,  8'h00},
        '{8'b1010_0101, 1'b0, 1'b0, 4'd7,  8'b0110_1001},
        '{8'b0100_0010, 1'b1, 1'b0, 4'd15, 8'h00},
        '{8'b1000_0001, 1'b0, 1'b1, 4'd1,  8'b1111_0000},
        '{8'b0011_1000, 1'b0, 1'b0, 4'd5,  8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] req = '0, ser = '0, tok;
    logic mode = 1'b0, shutter = 1'b0, eoc_full = 1'b0, dp;
    logic [3:0] dead = '0;
    logic [7:0] cdata, stall_pat = '0;
    logic [PW-1:0] pay [NP];
    int idx [NP];
    int cyc = 0, nchk = 0, nfail = 0, blast = NP - 1;
    int tlen = 0, gap = 0, tokbad = 0, ohbad = 0;
    logic [NP-1:0] ptok = '0;
    logic [7:0] words [$];
    int grants [$];
    int gaps [$];

    always #2 clk = ~clk;

    sp_readout_conc u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pix_req_i(req), .pix_ser_i(ser),
        .pix_tok_o(tok), .mode_i(mode), .shutter_i(shutter), .dead_cfg_i(dead),
        .eoc_full_i(eoc_full), .col_data_o(cdata), .col_dp_o(dp)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pixel model and back-pressure, driven just after the rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (tok[p]) begin
                    ser[p] = pay[p][PW-1-idx[p]];
                    idx[p]++;
                    if (idx[p] == PW) req[p] = 1'b0;
                end
            end
            eoc_full = stall_pat[cyc % 8];
            cyc++;
        end else begin
            eoc_full = 1'b0;
        end
    end

    // monitor, sampling at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dp && !eoc_full) words.push_back(cdata);
            if (!$onehot0(tok)) ohbad++;
            for (int p = 0; p < NP; p++)
                if (tok[p] && !ptok[p]) grants.push_back(p);
            if (|tok && !(|ptok)) gaps.push_back(gap);
            if (|tok) begin gap = 0; tlen++; end
            else begin
                gap++;
                if (|ptok) begin
                    if (tlen != PW) tokbad++;
                    tlen = 0;
                end
            end
            ptok = tok;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        nfail++; nchk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    task automatic raise(input logic [7:0] mask, input int seed);
        for (int p = 0; p < NP; p++) begin
            if (mask[p]) begin
                pay[p] = PW'((64'h9E37_79B9_7F4A_7C15 * 64'(seed * 8 + p + 1)) >> 13);
                idx[p] = 0;
                req[p] = 1'b1;
            end
        end
    endtask

    task automatic wait_done();
        int idle = 0;
        while (idle < 24) begin
            @(negedge clk);
            if (req == '0 && tok == '0 && !dp) idle++;
            else idle = 0;
        end
    endtask

    task automatic verify(input logic [7:0] mask, input bit gapchk, input int dcfg);
        int ord [$];
        int ptr = blast;
        for (int k = 1; k <= NP; k++) begin
            int p = (ptr + k) % NP;
            if (mask[p]) ord.push_back(p);
        end
        chk(grants.size() == ord.size(), "R2 grant count", grants.size(), ord.size());
        for (int i = 0; i < ord.size() && i < grants.size(); i++)
            chk(grants[i] == ord[i], "R2 grant order", grants[i], ord[i]);
        chk(words.size() == NW * ord.size(), "R5 word count", words.size(), NW * ord.size());
        for (int i = 0; i < ord.size() && NW * i + NW - 1 < words.size(); i++) begin
            logic [39:0] got, exp;
            got = {words[NW*i], words[NW*i+1], words[NW*i+2], words[NW*i+3], words[NW*i+4]};
            exp = {3'(ord[i]), pay[ord[i]]};
            chk(got == exp, "R5/R3 record content", got, exp);
        end
        chk(tokbad == 0, "R3 token width", tokbad, 0);
        chk(ohbad == 0, "R1 token one-hot", ohbad, 0);
        if (gapchk)
            for (int i = 1; i < gaps.size(); i++)
                chk(gaps[i] == dcfg + 1, "R4 token gap", gaps[i], dcfg + 1);
        if (ord.size() > 0) blast = ord[ord.size()-1];
        words.delete(); grants.delete(); gaps.delete();
        tokbad = 0; ohbad = 0;
    endtask

    initial begin
        logic [7:0] held;
        for (int p = 0; p < NP; p++) begin pay[p] = '0; idx[p] = 0; end
        repeat (3) @(negedge clk);
        chk(tok == '0, "R9 reset token", tok, 0);
        chk(dp == 1'b0, "R9 reset data-present", dp, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(tok == '0 && dp == 1'b0, "R9 after reset", {tok, dp}, 0);

        // table-driven runs
        for (int v = 0; v < 6; v++) begin
            mode = VECS[v].mode; shutter = VECS[v].shut;
            dead = VECS[v].dead; stall_pat = VECS[v].stall;
            raise(VECS[v].mask, v);
            wait_done();
            // R8: continuous mode ignores an open shutter; R6: stalls lose nothing
            verify(VECS[v].mask, VECS[v].stall == 8'h00, int'(VECS[v].dead));
        end
        stall_pat = '0; shutter = 1'b0;

        // R8: gated mode holds off while shutter open
        mode = 1'b1; shutter = 1'b1; dead = 4'd2;
        raise(8'b0001_0100, 10);
        repeat (100) @(negedge clk);
        chk(grants.size() == 0, "R8 gated no token", grants.size(), 0);
        chk(tok == '0, "R8 gated token lines", tok, 0);
        shutter = 1'b0;
        wait_done();
        verify(8'b0001_0100, 1'b1, 2);
        mode = 1'b0;

        // R7/R6: capacity under sustained back-pressure
        dead = 4'd0; stall_pat = 8'hFF;
        raise(8'b0110_0110, 11);
        repeat (300) @(negedge clk);
        chk(grants.size() == 3, "R7 capacity grants", grants.size(), 3);
        chk(words.size() == 0, "R6 no word while full", words.size(), 0);
        chk(dp == 1'b1, "R6 data-present held", dp, 1);
        held = cdata;
        repeat (50) @(negedge clk);
        chk(cdata == held, "R6 word stable", cdata, held);
        chk(grants.size() == 3, "R7 still blocked", grants.size(), 3);
        stall_pat = 8'h00;
        wait_done();
        verify(8'b0110_0110, 1'b0, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule